// File: doc/BRIEF.md
# Canary SRAM Reverse-Assist Sweep Sequencer

This controller drives a small canary SRAM so that the bench around it, or a failure-counting engine on the chip, can see how write failures grow as a reverse write assist gets stronger. The array holds 512 bits, arranged as 32 words of 16 bits. For each assist setting the controller runs three back-to-back address passes. First it loads a background pattern into every word with the assist disabled. Next it writes the bitwise complement of that background with the assist enabled at the current strength. Last it reads every word back. Each word that comes back is handed to the checker together with the data it should hold and the setting and polarity it belongs to.

The assist select steps upward from 0 (weakest) to 7 (strongest). The whole sweep runs twice. The first time measures the write-0 trend: the background is all ones and the complement written is all zeros. The second time measures the write-1 trend: the background is all zeros and the complement written is all ones. One run takes 2 × 8 × 3 × 32 = 1536 cycles. After it the controller raises `done` and waits for the next `start`.

Top module: `canary_sweep_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the controller is idle: `busy`=0, `done`=0, `mem_we`=0, `mem_re`=0, `assist_en`=0, `assist_sel`=0, `chk_valid`=0.
- R2: The initialisation pass writes addresses 0 to 31 in ascending order, one per cycle, with `mem_we`=1 and `assist_en`=0. The write data is all ones when `polarity`=0 and all zeros when `polarity`=1.
- R3: The complement pass follows on the next cycle. It writes addresses 0 to 31 in ascending order with `mem_we`=1, `assist_en`=1, `assist_sel` at the current setting, and data equal to the bitwise complement of the initialisation pattern.
- R4: The read pass follows on the next cycle. It reads addresses 0 to 31 in ascending order with `mem_re`=1 and `mem_we`=0. The controller never raises read and write enable in the same cycle.
- R5: `chk_valid` is high exactly one cycle after each cycle with `mem_re`=1. In that cycle `chk_rdata` equals the memory's read data, `chk_expect` equals the complement pattern of the read's polarity, and `chk_sel`/`chk_pol` equal the assist setting and polarity that were current when the read was issued.
- R6: The assist select takes the values 0 to 7 in ascending order. Each value covers one 96-cycle block of initialisation, complement write and read passes.
- R7: Polarity 0 (write-0 trend) is swept completely before polarity 1 (write-1 trend). `busy` stays high for exactly 1536 cycles after an accepted start.
- R8: `done` goes high in the cycle after the last read is issued. It holds, with `busy`=0 and no memory access, until the next `start`, which begins a new complete run.
- R9: A `start` pulse that arrives while `busy`=1 has no effect on the running sequence.
- R10: Asserting reset in the middle of a run returns the controller to idle at once, with the assist disabled.
- R11: With stuck-at and assist-sensitive cells placed in the memory, the bit mismatches between `chk_rdata` and `chk_expect` add up, for each polarity and setting, to the number of cells that fail the complement write at that setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the controller is idle or done |
| mem_rdata | input | 16 | Read data from the canary memory, one cycle after `mem_re` |
| mem_addr | output | 5 | Word address to the memory |
| mem_wdata | output | 16 | Write data to the memory |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| assist_en | output | 1 | Reverse write assist enable, high only in the complement pass |
| assist_sel | output | 3 | Current reverse-assist setting |
| polarity | output | 1 | Current trend: 0 = write zeros, 1 = write ones |
| chk_valid | output | 1 | Read word valid for the failure checker |
| chk_rdata | output | 16 | Read word forwarded to the checker |
| chk_expect | output | 16 | Value the read word should hold |
| chk_sel | output | 3 | Assist setting the read word belongs to |
| chk_pol | output | 1 | Polarity the read word belongs to |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |

## Verification
The case that is hardest to reach from the ports is a cell that writes correctly at weak assist and fails only above some setting. Catching it needs a memory that knows the assist strength and keeps its old value on those bits. The bench's memory model takes the select and enable straight from the controller. It holds per-word masks for stuck-at-0, stuck-at-1 and threshold-sensitive cells, and from those masks it works out arithmetically the mismatch count for every polarity and setting. A start pulse in mid-run, a reset in mid-run and a restart from done are laid over full cycle-by-cycle sweeps. Every cycle is compared against the position computed from its cycle index.

// File: rtl/canary_sweep_ctrl.sv
module canary_sweep_ctrl #(
  parameter int WORDS = 32,
  parameter int WIDTH = 16,
  parameter int SEL_W = 3,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic [WIDTH-1:0] mem_wdata,
  output logic             mem_we,
  output logic             mem_re,
  output logic             assist_en,
  output logic [SEL_W-1:0] assist_sel,
  output logic             polarity,
  output logic             chk_valid,
  output logic [WIDTH-1:0] chk_rdata,
  output logic [WIDTH-1:0] chk_expect,
  output logic [SEL_W-1:0] chk_sel,
  output logic             chk_pol,
  output logic             busy,
  output logic             done
);
  localparam logic [AW-1:0]    LAST_ADDR = AW'(WORDS - 1);
  localparam logic [SEL_W-1:0] LAST_SEL  = {SEL_W{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_WRITE, S_READ, S_DONE} state_t;

  state_t           st;
  logic [AW-1:0]    addr;
  logic [SEL_W-1:0] sel;
  logic             pol;
  logic             rd_q;
  logic [SEL_W-1:0] rd_sel;
  logic             rd_pol;

  wire last = (addr == LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      sel    <= '0;
      pol    <= 1'b0;
      rd_q   <= 1'b0;
      rd_sel <= '0;
      rd_pol <= 1'b0;
    end else begin
      rd_q   <= (st == S_READ);
      rd_sel <= sel;
      rd_pol <= pol;
      case (st)
        S_IDLE, S_DONE: if (start) begin
          st   <= S_INIT;
          addr <= '0;
          sel  <= '0;
          pol  <= 1'b0;
        end
        S_INIT: begin
          addr <= last ? '0 : addr + 1'b1;
          if (last) st <= S_WRITE;
        end
        S_WRITE: begin
          addr <= last ? '0 : addr + 1'b1;
          if (last) st <= S_READ;
        end
        S_READ: begin
          addr <= last ? '0 : addr + 1'b1;
          if (last) begin
            if (sel != LAST_SEL) begin
              sel <= sel + 1'b1;
              st  <= S_INIT;
            end else if (!pol) begin
              pol <= 1'b1;
              sel <= '0;
              st  <= S_INIT;
            end else begin
              st <= S_DONE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr   = addr;
  assign mem_we     = (st == S_INIT) || (st == S_WRITE);
  assign mem_re     = (st == S_READ);
  assign assist_en  = (st == S_WRITE);
  assign mem_wdata  = {WIDTH{pol ^ (st == S_INIT)}};
  assign assist_sel = sel;
  assign polarity   = pol;
  assign chk_valid  = rd_q;
  assign chk_rdata  = mem_rdata;
  assign chk_expect = {WIDTH{rd_pol}};
  assign chk_sel    = rd_sel;
  assign chk_pol    = rd_pol;
  assign busy       = (st == S_INIT) || (st == S_WRITE) || (st == S_READ);
  assign done       = (st == S_DONE);
endmodule

module canary_sweep_ctrl_chk #(
  parameter int WORDS = 32,
  parameter int WIDTH = 16,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             mem_we,
  input logic             mem_re,
  input logic             assist_en,
  input logic [AW-1:0]    mem_addr,
  input logic [WIDTH-1:0] mem_wdata,
  input logic             polarity,
  input logic             chk_valid
);
  localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1);

  // R2
  init_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !assist_en) |-> mem_wdata == {WIDTH{~polarity}});
  // R3
  comp_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && assist_en) |-> mem_wdata == {WIDTH{polarity}});
  // R4
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> chk_valid);
  // R5
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> !chk_valid);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_we && !mem_re));
  // R10
  idle_assist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !assist_en);
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      mem_addr == (($past(mem_addr) == LAST_A) ? '0 : AW'($past(mem_addr) + 1'b1)));
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && mem_addr != LAST_A) |=>
      (busy && mem_addr == AW'($past(mem_addr) + 1'b1)));
endmodule

bind canary_sweep_ctrl canary_sweep_ctrl_chk #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_we(mem_we), .mem_re(mem_re), .assist_en(assist_en),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .polarity(polarity),
  .chk_valid(chk_valid)
);

// File: tb/canary_sweep_ctrl_bench.sv
module canary_sweep_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 32;
  localparam int W  = 16;
  localparam int RUN = 1536;

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] mem_rdata;
  logic [4:0] mem_addr;
  logic [W-1:0] mem_wdata, chk_rdata, chk_expect;
  logic mem_we, mem_re, assist_en, polarity, chk_valid, chk_pol, busy, done;
  logic [2:0] assist_sel, chk_sel;

  int checks = 0, failures = 0;
  logic [W-1:0] mem [NW];
  logic [W-1:0] s1 [NW];
  logic [W-1:0] s0 [NW];
  logic [W-1:0] wk [NW];
  int thr [NW];
  int acc [2][8];

  always #(CLK_PERIOD/2) clk = ~clk;

  canary_sweep_ctrl u_canary_sweep_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .assist_en(assist_en), .assist_sel(assist_sel), .polarity(polarity),
    .chk_valid(chk_valid), .chk_rdata(chk_rdata), .chk_expect(chk_expect),
    .chk_sel(chk_sel), .chk_pol(chk_pol), .busy(busy), .done(done));

  always @(posedge clk) begin
    if (mem_we) begin
      logic [W-1:0] nv;
      nv = mem_wdata;
      if (assist_en && int'(assist_sel) >= thr[mem_addr])
        nv = (nv & ~wk[mem_addr]) | (mem[mem_addr] & wk[mem_addr]);
      mem[mem_addr] <= (nv | s1[mem_addr]) & ~s0[mem_addr];
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic check(string tag, logic ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_faults();
    for (int w = 0; w < NW; w++) begin
      s1[w] = '0; s0[w] = '0; wk[w] = '0; thr[w] = 8; mem[w] = '0;
    end
  endtask

  task automatic handle_valid(int k);
    int pk, ep, es;
    pk = k - 1;
    ep = pk / 768;
    es = (pk / 96) % 8;
    // R5: read word tagged and forwarded
    check("R5 chk_sel", chk_sel == 3'(es), chk_sel, es);
    check("R5 chk_pol", chk_pol == 1'(ep), chk_pol, ep);
    check("R5 chk_expect", chk_expect == {W{1'(ep)}}, chk_expect, {W{1'(ep)}});
    check("R5 chk_rdata", chk_rdata == mem_rdata, chk_rdata, mem_rdata);
    acc[chk_pol][chk_sel] += $countones(chk_rdata ^ chk_expect);
  endtask

  task automatic full_run(bit poke_start);
    foreach (acc[p, s]) acc[p][s] = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int k = 0; k < RUN; k++) begin
      int ep, es, ph, ea;
      ep = k / 768; es = (k / 96) % 8; ph = (k / 32) % 3; ea = k % 32;
      check("R7 busy", busy == 1'b1 && done == 1'b0, {busy, done}, 2'b10);
      check("R2 addr order", mem_addr == 5'(ea), mem_addr, ea);
      // R6 / R7: setting and polarity ordering
      check("R6 sel", assist_sel == 3'(es), assist_sel, es);
      check("R7 polarity", polarity == 1'(ep), polarity, ep);
      if (ph == 0) begin
        check("R2 init ctl", mem_we && !mem_re && !assist_en, {mem_we, mem_re, assist_en}, 3'b100);
        check("R2 init data", mem_wdata == {W{~1'(ep)}}, mem_wdata, {W{~1'(ep)}});
      end else if (ph == 1) begin
        check("R3 comp ctl", mem_we && !mem_re && assist_en, {mem_we, mem_re, assist_en}, 3'b101);
        check("R3 comp data", mem_wdata == {W{1'(ep)}}, mem_wdata, {W{1'(ep)}});
      end else begin
        check("R4 read ctl", !mem_we && mem_re, {mem_we, mem_re}, 2'b01);
      end
      if (k > 0 && ((k - 1) / 32) % 3 == 2) begin
        check("R5 valid", chk_valid, chk_valid, 1);
        handle_valid(k);
      end else begin
        check("R5 no valid", !chk_valid, chk_valid, 0);
      end
      if (poke_start && k == 500) start = 1;
      else start = 0;
      @(negedge clk);
    end
    // R8: done rises after last read, last word still delivered
    check("R8 done", done && !busy, {done, busy}, 2'b10);
    check("R5 last valid", chk_valid, chk_valid, 1);
    if (chk_valid) handle_valid(RUN);
    @(negedge clk);
    check("R8 done held", done && !busy && !mem_we && !mem_re && !chk_valid,
          {done, busy, mem_we, mem_re, chk_valid}, 5'b10000);
    // R11: mismatch counts per polarity and setting
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 8; s++) begin
        int e = 0;
        for (int w = 0; w < NW; w++) begin
          e += (p == 0) ? $countones(s1[w]) : $countones(s0[w]);
          if (s >= thr[w]) e += $countones(wk[w]);
        end
        check("R11 fail count", acc[p][s] == e, acc[p][s], e);
      end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_faults();
    s1[3]  = 16'h0020;
    s0[17] = 16'h0201;
    wk[8]  = 16'h000C; thr[8] = 4;
    wk[31] = 16'h8000; thr[31] = 7;
    wk[0]  = 16'h0001; thr[0] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", !busy && !done && !mem_we && !mem_re && !assist_en && assist_sel == 0 && !chk_valid,
          {busy, done, mem_we, mem_re, assist_en, assist_sel, chk_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", !busy && !done && !mem_we && !mem_re && !assist_en,
          {busy, done, mem_we, mem_re, assist_en}, 0);
    // R9: start pulse injected mid-run, sequence checked cycle by cycle
    full_run(1);
    // R8: restart from done, then R10: reset mid-run
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check("R8 restart", busy && !done, {busy, done}, 2'b10);
    repeat (130) @(negedge clk);
    check("R10 in write pass", assist_en, assist_en, 1);
    rst_n = 0;
    #1;
    check("R10 reset mid-run", !busy && !done && !mem_we && !mem_re && !assist_en && assist_sel == 0,
          {busy, done, mem_we, mem_re, assist_en, assist_sel}, 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R10 idle after", !busy && !assist_en, {busy, assist_en}, 0);
    clear_faults();
    s0[5]  = 16'hF000;
    s1[30] = 16'h0003;
    wk[12] = 16'h0F00; thr[12] = 2;
    full_run(0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule